// File: doc/BRIEF.md
# Three-Capacitor Cyclic Converter Phase Sequencer

This block is the control state machine for a cyclic analog-to-digital converter whose switched-capacitor core has three capacitors. One capacitor serves as the amplifier feedback element. The other two swap between two jobs on alternating phases: one is driven by the three-level reference chosen from the previous decision, and the other samples the new residue. Because of this swap, every clock phase completes one conversion step and no extra phase is spent on re-sampling. The sequencer drives all capacitor switch enables from a fast clock. Between any two phases it inserts a programmable non-overlap gap in which every switch is open.

When a conversion start tick arrives, an initialisation phase samples the input onto the first two capacitors. Amplifying phases then follow, alternating between even and odd. At the end of every phase the two comparator outputs are latched into a reference select. That select drives the reference during the following phase. A one-cycle strobe tells the downstream correction logic that a new decision is ready. A conversion produces a fixed number of decisions and then returns to idle. A start tick that arrives while a conversion is running is ignored.

Top module: `cyc3_seq`

## Requirements
- R1: While reset is active and in the cycle after it is released, all phase and switch outputs are low, `dec_valid` is low and `dac_sel` is 2'b01 (common mode).
- R2: A `start` high in an idle cycle begins an initialisation phase in the next cycle. This phase lasts PHASE_CYC cycles with `phase_en` = 3'b001 and only `c1_in`, `c2_in` and `c3_dac` high.
- R3: After initialisation, N_DEC-1 amplifying phases of PHASE_CYC cycles each follow, alternating even (`phase_en` = 3'b010) first, then odd (3'b100). The sequencer then returns to idle.
- R4: In an even phase only `c1_fb`, `c2_dac` and `c3_res` are high. In an odd phase only `c1_fb`, `c3_dac` and `c2_res` are high. Feedback is never closed while input sampling is on, and no capacitor is driven and sampling at once.
- R5: At most one bit of `phase_en` is high. After every phase, including the last, there is a gap of max(`gap_len`,1) cycles in which every phase and switch output is low. Two different phases are never adjacent.
- R6: In the last cycle of each phase the comparators are sampled. From the next cycle `dac_sel` is 2'b10 (high reference) if `cmp_hi` is 1, 2'b01 (common mode) if only `cmp_lo` is 1, and 2'b00 (low reference) if both are 0. The value 2'b11 never appears.
- R7: `dac_sel` keeps its value in every cycle without a strobe, so a decision stays in force through the following gap and the following phase.
- R8: `dec_valid` is a one-cycle pulse in the first gap cycle after each phase, in the same cycle as the `dac_sel` update. It pulses N_DEC times per conversion.
- R9: A `start` high during any phase or gap of a running conversion, including the trailing gap, is ignored. The conversion is neither restarted nor shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion start tick at the sample rate |
| gap_len | input | GAP_W | Non-overlap gap length in clock cycles (0 is treated as 1) |
| cmp_hi | input | 1 | Comparator output, residue above +Vref/4 |
| cmp_lo | input | 1 | Comparator output, residue above -Vref/4 |
| phase_en | output | 3 | Active phase: bit0 initialisation, bit1 even, bit2 odd |
| c1_in | output | 1 | Connect C1 to the analog input |
| c2_in | output | 1 | Connect C2 to the analog input |
| c1_fb | output | 1 | Connect C1 as amplifier feedback |
| c2_dac | output | 1 | Drive C2 from the reference select |
| c2_res | output | 1 | Let C2 sample the residue |
| c3_dac | output | 1 | Drive C3 from the reference select |
| c3_res | output | 1 | Let C3 sample the residue |
| dac_sel | output | 2 | Latched reference select (00 low, 01 common mode, 10 high) |
| dec_valid | output | 1 | One-cycle strobe marking a new decision |

## Verification
The assertions check on every cycle that phases are mutually exclusive, that no two different phases touch, and that the gap before each amplifying phase is at least the effective gap length. On every cycle they also check the switch-role exclusions, that the reference select never takes the unused code and changes only together with the strobe, and that the strobe always falls in the first cycle after a phase. Other properties need the bench's scenarios: the exact phase order and length, the count of decisions per conversion, the mapping of each comparator pair to its reference code, and the way a start tick is ignored inside a conversion. The bench sweeps gap lengths and comparator patterns for these, and also places start ticks in the initialisation phase, in the middle of a conversion and in its trailing gap.

// File: rtl/cyc3_pkg.sv
// Shared types for the three-capacitor cyclic converter sequencer.
// Assumes: comparator pair is thermometer-like but may be inconsistent;
// the high comparator wins.
package cyc3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_GAP  = 2'd2,
        ST_AMP  = 2'd3
    } seq_state_t;

    localparam logic [1:0] SEL_LOW  = 2'b00;
    localparam logic [1:0] SEL_MID  = 2'b01;
    localparam logic [1:0] SEL_HIGH = 2'b10;

    // Map the two comparator outputs to a three-level reference select.
    function automatic logic [1:0] decide(input logic hi, input logic lo);
        if (hi)
            return SEL_HIGH;
        else if (lo)
            return SEL_MID;
        else
            return SEL_LOW;
    endfunction

endpackage

// File: rtl/cyc3_seq_ctrl.sv
// Phase sequencer core: walks idle -> init -> (gap -> amplify)* -> gap -> idle.
// A single down-counter times both phases and gaps.
// Assumes: gap_len is stable during a conversion; 0 is treated as 1.
module cyc3_seq_ctrl
    import cyc3_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int N_DEC     = 14,
    parameter int GAP_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap_len,
    output seq_state_t       state,
    output logic             odd_ph,
    output logic             sample_now
);

    localparam int TMR_MAX = (PHASE_CYC > (1 << GAP_W)) ? PHASE_CYC : (1 << GAP_W);
    localparam int TMR_W   = $clog2(TMR_MAX);
    localparam int STEP_W  = $clog2(N_DEC);
    localparam logic [TMR_W-1:0]  PH_LOAD   = TMR_W'(PHASE_CYC - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_DEC - 1);

    logic [TMR_W-1:0]  tmr;
    logic [STEP_W-1:0] step;
    logic [TMR_W-1:0]  gap_load;

    // Gap reload value, forcing a minimum of one cycle.
    always_comb begin
        if (gap_len == '0)
            gap_load = '0;
        else
            gap_load = TMR_W'(gap_len) - 1'b1;
    end

    // Comparator sampling instant: last cycle of a switch-active phase.
    always_comb begin
        sample_now = ((state == ST_INIT) || (state == ST_AMP)) && (tmr == '0);
    end

    // State, timer, step count and even/odd parity update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            step   <= '0;
            odd_ph <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_INIT;
                        tmr    <= PH_LOAD;
                        step   <= '0;
                        odd_ph <= 1'b0;
                    end
                end
                ST_INIT, ST_AMP: begin
                    if (tmr == '0) begin
                        state <= ST_GAP;
                        tmr   <= gap_load;
                        if (state == ST_AMP)
                            step <= step + 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tmr == '0) begin
                        if (step == LAST_STEP) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_AMP;
                            tmr    <= PH_LOAD;
                            odd_ph <= step[0];
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cyc3_seq_dlatch.sv
// Decision latch: captures the comparator pair at the end of a phase and
// holds the reference select until the next capture; pulses a strobe.
// Assumes: comparators are settled in the cycle flagged by sample_now.
module cyc3_seq_dlatch
    import cyc3_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_now,
    input  logic       cmp_hi,
    input  logic       cmp_lo,
    output logic [1:0] dac_sel,
    output logic       dec_valid
);

    // Latch the decision and raise the strobe in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_sel   <= SEL_MID;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= sample_now;
            if (sample_now)
                dac_sel <= decide(cmp_hi, cmp_lo);
        end
    end

endmodule

// File: rtl/cyc3_seq_swdec.sv
// Switch decoder: turns the sequencer state into phase flags and
// per-capacitor switch enables; all low outside an active phase.
// Assumes: state and parity come straight from registers (glitch-free).
module cyc3_seq_swdec
    import cyc3_pkg::*;
(
    input  seq_state_t state,
    input  logic       odd_ph,
    output logic [2:0] phase_en,
    output logic       c1_in,
    output logic       c2_in,
    output logic       c1_fb,
    output logic       c2_dac,
    output logic       c2_res,
    output logic       c3_dac,
    output logic       c3_res
);

    logic ph_init, ph_even, ph_odd;

    // Phase flags from state and parity.
    always_comb begin
        ph_init  = (state == ST_INIT);
        ph_even  = (state == ST_AMP) && !odd_ph;
        ph_odd   = (state == ST_AMP) &&  odd_ph;
        phase_en = {ph_odd, ph_even, ph_init};
    end

    // Capacitor roles per phase.
    always_comb begin
        c1_in  = ph_init;
        c2_in  = ph_init;
        c1_fb  = ph_even | ph_odd;
        c2_dac = ph_even;
        c3_res = ph_even;
        c3_dac = ph_odd | ph_init;
        c2_res = ph_odd;
    end

endmodule

// File: rtl/cyc3_seq.sv
// Top of the three-capacitor cyclic converter sequencer.
// Connects the phase controller, switch decoder and decision latch.
// Assumes: start is a single-cycle tick; gap_len is held per conversion.
module cyc3_seq
    import cyc3_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int N_DEC     = 14,
    parameter int GAP_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             cmp_hi,
    input  logic             cmp_lo,
    output logic [2:0]       phase_en,
    output logic             c1_in,
    output logic             c2_in,
    output logic             c1_fb,
    output logic             c2_dac,
    output logic             c2_res,
    output logic             c3_dac,
    output logic             c3_res,
    output logic [1:0]       dac_sel,
    output logic             dec_valid
);

    seq_state_t state;
    logic       odd_ph;
    logic       sample_now;

    cyc3_seq_ctrl #(
        .PHASE_CYC (PHASE_CYC),
        .N_DEC     (N_DEC),
        .GAP_W     (GAP_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gap_len    (gap_len),
        .state      (state),
        .odd_ph     (odd_ph),
        .sample_now (sample_now)
    );

    cyc3_seq_swdec u_swdec (
        .state    (state),
        .odd_ph   (odd_ph),
        .phase_en (phase_en),
        .c1_in    (c1_in),
        .c2_in    (c2_in),
        .c1_fb    (c1_fb),
        .c2_dac   (c2_dac),
        .c2_res   (c2_res),
        .c3_dac   (c3_dac),
        .c3_res   (c3_res)
    );

    cyc3_seq_dlatch u_dlatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .cmp_hi     (cmp_hi),
        .cmp_lo     (cmp_lo),
        .dac_sel    (dac_sel),
        .dec_valid  (dec_valid)
    );

endmodule

// File: rtl/cyc3_seq_chk.sv
// Property checker for cyc3_seq, attached by bind below.
// Observes ports only; keeps a saturating run counter of all-off cycles.
module cyc3_seq_chk #(
    parameter int GAP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GAP_W-1:0] gap_len,
    input logic [2:0]       phase_en,
    input logic             c1_in,
    input logic             c2_in,
    input logic             c1_fb,
    input logic             c2_dac,
    input logic             c2_res,
    input logic             c3_dac,
    input logic             c3_res,
    input logic [1:0]       dac_sel,
    input logic             dec_valid
);

    localparam int RUN_W = GAP_W + 2;
    localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

    logic [RUN_W-1:0] off_run;
    logic             seen_phase;
    logic [RUN_W-1:0] gap_min;

    // Minimum gap actually required.
    always_comb begin
        gap_min = (gap_len == '0) ? RUN_W'(1) : RUN_W'(gap_len);
    end

    // Count consecutive cycles with no phase active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run    <= '0;
            seen_phase <= 1'b0;
        end else begin
            if (phase_en == 3'b000)
                off_run <= (off_run == RUN_SAT) ? off_run : off_run + 1'b1;
            else begin
                off_run    <= '0;
                seen_phase <= 1'b1;
            end
        end
    end

    // R5
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_en));

    // R5
    phase_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_en != 3'b000) && ($past(phase_en) != 3'b000)) |-> (phase_en == $past(phase_en)));

    // R5
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_phase && (phase_en != 3'b000) && ($past(phase_en) == 3'b000)) |-> (off_run >= gap_min));

    // R4
    fb_vs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c1_fb |-> (!c1_in && !c2_in));

    // R4
    cap_role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(c2_dac && c2_res) && !(c3_dac && c3_res));

    // R6
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sel != 2'b11);

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(dac_sel));

    // R8
    strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((phase_en == 3'b000) && ($past(phase_en) != 3'b000)));

endmodule

bind cyc3_seq cyc3_seq_chk #(.GAP_W(GAP_W)) u_cyc3_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gap_len   (gap_len),
    .phase_en  (phase_en),
    .c1_in     (c1_in),
    .c2_in     (c2_in),
    .c1_fb     (c1_fb),
    .c2_dac    (c2_dac),
    .c2_res    (c2_res),
    .c3_dac    (c3_dac),
    .c3_res    (c3_res),
    .dac_sel   (dac_sel),
    .dec_valid (dec_valid)
);

// File: tb/test_cyc3_seq.sv
// Bench for cyc3_seq: sweeps gap lengths, comparator patterns and
// start-tick placements; expected timeline is computed arithmetically.
module test_cyc3_seq;

    localparam int P     = 4;
    localparam int N     = 14;
    localparam int GAP_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [GAP_W-1:0] gap_len = '0;
    logic             cmp_hi = 1'b0;
    logic             cmp_lo = 1'b0;
    logic [2:0]       phase_en;
    logic             c1_in, c2_in, c1_fb, c2_dac, c2_res, c3_dac, c3_res;
    logic [1:0]       dac_sel;
    logic             dec_valid;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [1:0] exp_sel = 2'b01;

    cyc3_seq #(.PHASE_CYC(P), .N_DEC(N), .GAP_W(GAP_W)) i_cyc3_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .gap_len(gap_len),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .phase_en(phase_en),
        .c1_in(c1_in), .c2_in(c2_in), .c1_fb(c1_fb), .c2_dac(c2_dac),
        .c2_res(c2_res), .c3_dac(c3_dac), .c3_res(c3_res),
        .dac_sel(dac_sel), .dec_valid(dec_valid)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] pat(input int seg, input int seed);
        return 2'((seg * 3 + seed * 5 + seg / 4) % 4);
    endfunction

    function automatic logic [1:0] ref_sel(input logic [1:0] c);
        if (c[1]) return 2'b10;
        if (c[0]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [6:0] sw_vec();
        return {c1_in, c2_in, c1_fb, c2_dac, c2_res, c3_dac, c3_res};
    endfunction

    // Check the all-idle output state for a number of cycles.
    task automatic idle_check(input int cycles, input string req);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check(phase_en == 3'b000, req, phase_en, 0);
            check(sw_vec() == 7'b0, req, sw_vec(), 0);
            check(!dec_valid, req, dec_valid, 0);
            check(dac_sel == exp_sel, req, dac_sel, exp_sel);
        end
    endtask

    // One full conversion; poke = cycle index with an extra start (-1 none).
    task automatic run_conv(input int gap, input int seed, input int poke);
        int geff, seg_len, total, strobes;
        geff    = (gap == 0) ? 1 : gap;
        seg_len = P + geff;
        total   = N * seg_len;
        strobes = 0;
        gap_len = GAP_W'(gap);
        @(negedge clk);
        start = 1'b1;
        {cmp_hi, cmp_lo} = pat(0, seed);
        for (int c = 0; c < total; c++) begin
            int seg, off;
            logic [2:0] exp_ph;
            logic [6:0] exp_sw;
            @(negedge clk);
            start = (c == poke);
            seg = c / seg_len;
            off = c % seg_len;
            if (off < P) begin
                if (seg == 0)          begin exp_ph = 3'b001; exp_sw = 7'b1100010; end
                else if (seg % 2 == 1) begin exp_ph = 3'b010; exp_sw = 7'b0011001; end
                else                   begin exp_ph = 3'b100; exp_sw = 7'b0010110; end
            end else begin
                exp_ph = 3'b000; exp_sw = 7'b0;
            end
            if (off == P) exp_sel = ref_sel(pat(seg, seed));
            if (dec_valid) strobes++;
            // R2 R3 R9 phase order and length; R5 gaps
            check(phase_en == exp_ph, (seg == 0) ? "R2" : "R3", phase_en, exp_ph);
            // R4 capacitor roles (R2 for init)
            check(sw_vec() == exp_sw, (exp_ph == 3'b000) ? "R5" : "R4", sw_vec(), exp_sw);
            // R8 strobe placement
            check(dec_valid == (off == P), "R8", dec_valid, (off == P));
            // R6 decode, R7 hold
            check(dac_sel == exp_sel, (off == P) ? "R6" : "R7", dac_sel, exp_sel);
            {cmp_hi, cmp_lo} = pat(seg, seed);
        end
        // R8 decision count per conversion
        check(strobes == N, "R8", strobes, N);
        start = 1'b0;
        // R9 a start in the trailing gap does not prolong the conversion
        idle_check(20, (poke >= 0) ? "R9" : "R3");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(phase_en == 3'b000, "R1", phase_en, 0);
        check(sw_vec() == 7'b0, "R1", sw_vec(), 0);
        check(dac_sel == 2'b01, "R1", dac_sel, 1);
        check(!dec_valid, "R1", dec_valid, 0);
        rst_n = 1'b1;
        idle_check(20, "R1");

        // R6 R7 sweep of gap lengths and comparator patterns
        for (int g = 0; g < 16; g += 3)
            for (int s = 0; s < 4; s++)
                run_conv(g, s, -1);
        run_conv(1, 7, -1);
        run_conv(15, 2, -1);

        // R9 starts in init, mid-conversion and trailing gap
        run_conv(2, 1, 0);
        run_conv(2, 3, 40);
        run_conv(3, 0, N * (P + 3) - 1);
        run_conv(0, 2, N * (P + 1) - 1);

        // R1 reset in the middle of a conversion
        gap_len = 4'd2;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_sel = 2'b01;
        check(phase_en == 3'b000, "R1", phase_en, 0);
        check(dac_sel == 2'b01, "R1", dac_sel, 1);
        idle_check(20, "R1");
        run_conv(1, 1, -1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule